// File: doc/BRIEF.md
# Card Power and Clock Controller

This block sits between the configuration registers of an SD/MMC host and its card pins. It sequences the card interface through three power states, and it produces the card clock from the kernel clock with a programmable divider. The power states are: drive every signal line low so the card cannot draw supply through its pins, drive the lines high with the interface disabled, or run. On entry to the run state the block sends a fixed number of card-clock cycles before it enables the command and data paths. It also reports which kernel-clock edge the command and data paths should launch on, and decodes the data-bus width.

A divider setting of zero bypasses the divider and forwards the kernel clock. Divider changes and clock stops only take effect at the end of a low phase of the card clock, so the card never sees a shortened pulse. An optional power-save mode parks the card clock low while both paths report idle.

The power sequencer has four states. `PS_OFF` is the reset state and is also entered on mode 00 or 01. `PS_CYCLE` is entered from any state on mode 10. `PS_WARM` is entered on mode 11 from `PS_OFF` or `PS_CYCLE`, and counts card-clock rising edges. `PS_RUN` is entered from `PS_WARM` on the last counted rising edge, and is held while the mode stays 11.

Top module: `card_pwrclk_ctrl`

## Requirements
- R1: Out of reset the line drive code is 10 (driven high), `if_en` is 0 and the card clock is low.
- R2: With `pwr_mode` = 10 (power-cycle) the line drive code is 01 (driven low), `if_en` is 0 and the card clock stays low.
- R3: With `pwr_mode` = 00 or 01 (power-off) the line drive code is 10 (driven high) and `if_en` is 0.
- R4: After `pwr_mode` becomes 11 from off or cycle, `if_en` stays 0 and lines stay driven high until the card clock has made WARMUP_CYC (default 74) rising edges. `if_en` rises together with the last of those edges, and the line drive code then becomes 00 (released, high-Z).
- R5: A nonzero divider N gives a card clock that is high for N and low for N kernel-clock cycles (period 2N).
- R6: A divider of 0 forwards the kernel clock as the card clock, and `launch_fall` is then 1.
- R7: With a nonzero divider, `launch_fall` equals `fall_sel`.
- R8: `dat_width` is 2 (8-bit) when `bus_w[1]` is set, otherwise 1 (4-bit) when `bus_w[0]` is set, otherwise 0 (1-bit).
- R9: In the run state with `pwr_save` = 1 and `path_busy` = 0, the card clock is held low and makes no rising edge. With `path_busy` = 1 it toggles again.
- R10: After a divider change, every card-clock high or low phase lasts at least the smaller of the old and new N, and the clock then settles to period 2 x new N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kclk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_mode | input | 2 | Power mode: 00/01 off, 10 cycle, 11 on |
| clk_div | input | DIV_W | Card clock divider N (0 = bypass) |
| fall_sel | input | 1 | Launch on falling edge when divider is nonzero |
| pwr_save | input | 1 | Stop card clock while paths are idle |
| bus_w | input | 2 | Bus width request: bit1 8-bit, bit0 4-bit |
| path_busy | input | 1 | Command or data path active |
| card_clk | output | 1 | Card clock |
| line_drive | output | 2 | 00 released/high-Z, 01 driven low, 10 driven high |
| if_en | output | 1 | Command and data paths enabled |
| launch_fall | output | 1 | Paths launch on the falling edge |
| dat_width | output | 2 | 0 1-bit, 1 4-bit, 2 8-bit |

## Verification
The bench counts the card-clock rising edges between the request for power-on and `if_en`. A warm-up counter that is off by one would give 73 or 75 edges, and one that counts kernel cycles would be off by a factor of 2N. It sweeps dividers 1 to 6 and measures phase widths, which catches a divider giving period N or 2N+2. It also changes the divider in the middle of a phase, where a design that reloads at once emits a runt pulse. The bypass setting is checked one nanosecond after the rising edge, because a design that mixed up zero and one would show a low clock there or a wrong launch edge. Power save with the paths idle must leave the clock parked low with no rising edge.

// File: rtl/card_pwrclk_pkg.sv
package card_pwrclk_pkg;
    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_CYCLE = 2'd1,
        PS_WARM  = 2'd2,
        PS_RUN   = 2'd3
    } pwr_state_t;

    localparam logic [1:0] LINE_REL  = 2'b00;
    localparam logic [1:0] LINE_LOW  = 2'b01;
    localparam logic [1:0] LINE_HIGH = 2'b10;

    localparam logic [1:0] MODE_CYCLE = 2'b10;
    localparam logic [1:0] MODE_ON    = 2'b11;
endpackage

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
    import card_pwrclk_pkg::*;
#(
    parameter int WARMUP_CYC = 74
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwr_mode,
    input  logic       rise_evt,
    output logic       if_en,
    output logic       run_req,
    output logic [1:0] line_drive
);
    localparam int WC_W = $clog2(WARMUP_CYC + 1);
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(WARMUP_CYC - 1);

    pwr_state_t st_q, st_d;
    logic [WC_W-1:0] wcnt_q;

    always_comb begin
        st_d = st_q;
        unique case (pwr_mode)
            MODE_CYCLE: st_d = PS_CYCLE;
            MODE_ON: begin
                if (st_q == PS_OFF || st_q == PS_CYCLE)
                    st_d = PS_WARM;
                else if (st_q == PS_WARM && rise_evt && wcnt_q == WC_LAST)
                    st_d = PS_RUN;
            end
            default: st_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PS_OFF;
            wcnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != PS_WARM)
                wcnt_q <= '0;
            else if (rise_evt)
                wcnt_q <= wcnt_q + 1'b1;
        end
    end

    always_comb begin
        unique case (st_q)
            PS_OFF:   begin line_drive = LINE_HIGH; if_en = 1'b0; run_req = 1'b0; end
            PS_CYCLE: begin line_drive = LINE_LOW;  if_en = 1'b0; run_req = 1'b0; end
            PS_WARM:  begin line_drive = LINE_HIGH; if_en = 1'b0; run_req = 1'b1; end
            PS_RUN:   begin line_drive = LINE_REL;  if_en = 1'b1; run_req = 1'b1; end
            default:  begin line_drive = LINE_HIGH; if_en = 1'b0; run_req = 1'b0; end
        endcase
    end
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_req,
    input  logic             run,
    output logic             ck_q,
    output logic             gate_q,
    output logic             bypass,
    output logic             rise_evt
);
    logic [DIV_W-1:0] div_act, cnt;
    logic [DIV_W:0]   cnt_inc;
    logic             at_top, boundary, rise_div;

    assign bypass   = (div_act == '0);
    assign cnt_inc  = {1'b0, cnt} + 1'b1;
    assign at_top   = cnt_inc >= {1'b0, div_act};
    assign boundary = bypass || (!ck_q && at_top);
    assign rise_div = boundary && run && (div_req != '0);
    assign rise_evt = rise_div || gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_act <= '0;
            cnt     <= '0;
            ck_q    <= 1'b0;
        end else if (boundary) begin
            div_act <= div_req;
            ck_q    <= rise_div;
            if (rise_div || bypass)
                cnt <= '0;
        end else if (ck_q && at_top) begin
            ck_q <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else
            gate_q <= bypass && run;
    end
endmodule

// File: rtl/card_pwrclk_ctrl.sv
module card_pwrclk_ctrl
    import card_pwrclk_pkg::*;
#(
    parameter int DIV_W      = 10,
    parameter int WARMUP_CYC = 74
) (
    input  logic             kclk,
    input  logic             rst_n,
    input  logic [1:0]       pwr_mode,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             fall_sel,
    input  logic             pwr_save,
    input  logic [1:0]       bus_w,
    input  logic             path_busy,
    output logic             card_clk,
    output logic [1:0]       line_drive,
    output logic             if_en,
    output logic             launch_fall,
    output logic [1:0]       dat_width
);
    logic run_req, run, rise_evt, ck_div, gate_q, bypass;

    card_pwr_seq #(.WARMUP_CYC(WARMUP_CYC)) u_seq (
        .clk        (kclk),
        .rst_n      (rst_n),
        .pwr_mode   (pwr_mode),
        .rise_evt   (rise_evt),
        .if_en      (if_en),
        .run_req    (run_req),
        .line_drive (line_drive)
    );

    assign run = run_req && !(if_en && pwr_save && !path_busy);

    card_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (kclk),
        .rst_n    (rst_n),
        .div_req  (clk_div),
        .run      (run),
        .ck_q     (ck_div),
        .gate_q   (gate_q),
        .bypass   (bypass),
        .rise_evt (rise_evt)
    );

    assign card_clk    = ck_div | (kclk & gate_q);
    assign launch_fall = bypass ? 1'b1 : fall_sel;

    always_comb begin
        if (bus_w[1])      dat_width = 2'd2;
        else if (bus_w[0]) dat_width = 2'd1;
        else               dat_width = 2'd0;
    end
endmodule

// File: rtl/card_pwrclk_chk.sv
module card_pwrclk_chk
    import card_pwrclk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pwr_mode,
    input logic       pwr_save,
    input logic       path_busy,
    input logic       if_en,
    input logic [1:0] line_drive,
    input logic       ck_div
);
    a_r2_cycle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == MODE_CYCLE) |=> (line_drive == LINE_LOW && !if_en));

    a_r3_off_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode[1] == 1'b0) |=> (line_drive == LINE_HIGH && !if_en));

    a_r4_no_early_en: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_en && pwr_mode != MODE_ON) |=> !if_en);

    a_r4_en_from_warm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_en) |-> ($past(line_drive) == LINE_HIGH));

    a_r9_save_park: assert property (@(posedge clk) disable iff (!rst_n)
        (if_en && pwr_save && !path_busy && !ck_div) |=> !ck_div);
endmodule

bind card_pwrclk_ctrl card_pwrclk_chk u_chk (
    .clk        (kclk),
    .rst_n      (rst_n),
    .pwr_mode   (pwr_mode),
    .pwr_save   (pwr_save),
    .path_busy  (path_busy),
    .if_en      (if_en),
    .line_drive (line_drive),
    .ck_div     (ck_div)
);

// File: tb/sim_card_pwrclk_ctrl.sv
`timescale 1ns/1ps
module sim_card_pwrclk_ctrl;
    localparam int DW = 10;
    localparam int WU = 74;

    logic          kclk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    pwr_mode = 2'b00;
    logic [DW-1:0] clk_div = 10'd2;
    logic          fall_sel = 1'b0;
    logic          pwr_save = 1'b0;
    logic [1:0]    bus_w = 2'b00;
    logic          path_busy = 1'b0;
    logic          card_clk, if_en, launch_fall;
    logic [1:0]    line_drive, dat_width;

    int errors = 0;
    int checks = 0;

    always #2 kclk = ~kclk;

    card_pwrclk_ctrl #(.DIV_W(DW), .WARMUP_CYC(WU)) u0 (
        .kclk(kclk), .rst_n(rst_n), .pwr_mode(pwr_mode), .clk_div(clk_div),
        .fall_sel(fall_sel), .pwr_save(pwr_save), .bus_w(bus_w),
        .path_busy(path_busy), .card_clk(card_clk), .line_drive(line_drive),
        .if_en(if_en), .launch_fall(launch_fall), .dat_width(dat_width)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Samples card_clk at falling edges; full phases only (first run dropped).
    task automatic measure(input int cyc, output int hmin, output int hmax,
                           output int lmin, output int lmax, output int rises);
        bit prev, first;
        int run;
        hmin = 1 << 30; hmax = 0; lmin = 1 << 30; lmax = 0; rises = 0;
        @(negedge kclk);
        prev = card_clk; run = 1; first = 1'b1;
        for (int i = 1; i < cyc; i++) begin
            @(negedge kclk);
            if (card_clk == prev) run++;
            else begin
                if (!first) begin
                    if (prev) begin hmin = (run < hmin) ? run : hmin; hmax = (run > hmax) ? run : hmax; end
                    else      begin lmin = (run < lmin) ? run : lmin; lmax = (run > lmax) ? run : lmax; end
                end
                if (card_clk) rises++;
                first = 1'b0; prev = card_clk; run = 1;
            end
        end
    endtask

    task automatic go_run(input int n);
        int rises;
        bit early;
        @(negedge kclk);
        clk_div = DW'(n);
        pwr_mode = 2'b11;
        rises = 0; early = 1'b0;
        for (int i = 0; i < 4000 && !if_en; i++) begin
            @(negedge kclk);
            if (card_clk && !if_en) rises++;
            else if (card_clk && if_en) rises++;
            if (!if_en && line_drive != 2'b10) early = 1'b1;
            if (card_clk) @(negedge kclk iff !card_clk or negedge if_en);
        end
        check(if_en == 1'b1, "R4 if_en reached", if_en, 1);
        check(rises == WU, "R4 rising edges before enable", rises, WU);
        check(!early, "R4 lines high during warm-up", early, 0);
        @(negedge kclk);
        check(line_drive == 2'b00, "R4 lines released in run", line_drive, 0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int hmin, hmax, lmin, lmax, rises;
        repeat (3) @(negedge kclk);
        // R1 reset state
        check(line_drive == 2'b10, "R1 line drive", line_drive, 2);
        check(if_en == 1'b0, "R1 if_en", if_en, 0);
        check(card_clk == 1'b0, "R1 card clock", card_clk, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge kclk);
        measure(20, hmin, hmax, lmin, lmax, rises);
        check(rises == 0 && line_drive == 2'b10, "R3 off after reset", rises, 0);

        // R4 warm-up count, divider 2
        go_run(2);

        // R5 divider sweep
        for (int n = 1; n <= 6; n++) begin
            @(negedge kclk); clk_div = DW'(n);
            repeat (4 * n + 4) @(negedge kclk);
            measure(12 * n + 4, hmin, hmax, lmin, lmax, rises);
            check(hmin == n && hmax == n, "R5 high width", hmin, n);
            check(lmin == n && lmax == n, "R5 low width", lmin, n);
            for (int f = 0; f < 2; f++) begin
                @(negedge kclk); fall_sel = f[0];
                @(negedge kclk);
                check(launch_fall == f[0], "R7 launch edge", launch_fall, f);
            end
        end

        // R10 glitch-free changes between divider pairs
        for (int a = 1; a <= 4; a++) begin
            for (int b = 1; b <= 4; b++) begin
                if (a == b) continue;
                @(negedge kclk); clk_div = DW'(a);
                repeat (4 * a + 4) @(negedge kclk);
                repeat (a / 2 + b % 2) @(negedge kclk);
                clk_div = DW'(b);
                measure(8 * a + 8 * b, hmin, hmax, lmin, lmax, rises);
                check(hmin >= ((a < b) ? a : b) && lmin >= ((a < b) ? a : b),
                      "R10 no runt pulse", (hmin < lmin) ? hmin : lmin, (a < b) ? a : b);
                measure(8 * b + 2, hmin, hmax, lmin, lmax, rises);
                check(hmin == b && hmax == b && lmin == b && lmax == b,
                      "R10 settled period", hmax + lmax, 2 * b);
            end
        end

        // R6 bypass
        @(negedge kclk); clk_div = '0; fall_sel = 1'b0;
        repeat (20) @(negedge kclk);
        begin
            int hi_cnt, lo_cnt;
            hi_cnt = 0; lo_cnt = 0;
            for (int i = 0; i < 10; i++) begin
                @(posedge kclk); #1;
                if (card_clk) hi_cnt++;
                @(negedge kclk); #0.5;
                if (!card_clk) lo_cnt++;
            end
            check(hi_cnt == 10, "R6 bypass high phases", hi_cnt, 10);
            check(lo_cnt == 10, "R6 bypass low phases", lo_cnt, 10);
        end
        check(launch_fall == 1'b1, "R6 bypass launch edge", launch_fall, 1);

        // R8 width decode, all codes
        for (int w = 0; w < 4; w++) begin
            @(negedge kclk); bus_w = w[1:0];
            #0.5;
            check(dat_width == (w[1] ? 2 : (w[0] ? 1 : 0)), "R8 width",
                  dat_width, w[1] ? 2 : (w[0] ? 1 : 0));
        end

        // R9 power save
        @(negedge kclk); clk_div = DW'(3);
        repeat (20) @(negedge kclk);
        pwr_save = 1'b1; path_busy = 1'b0;
        repeat (12) @(negedge kclk);
        measure(40, hmin, hmax, lmin, lmax, rises);
        check(rises == 0 && card_clk == 1'b0, "R9 parked while idle", rises, 0);
        check(if_en == 1'b1, "R9 paths stay enabled", if_en, 1);
        @(negedge kclk); path_busy = 1'b1;
        measure(40, hmin, hmax, lmin, lmax, rises);
        check(rises > 0, "R9 runs while busy", rises, 1);
        pwr_save = 1'b0; path_busy = 1'b0;

        // R2 power cycle
        @(negedge kclk); pwr_mode = 2'b10;
        repeat (8) @(negedge kclk);
        measure(30, hmin, hmax, lmin, lmax, rises);
        check(rises == 0 && card_clk == 1'b0, "R2 clock low", rises, 0);
        check(line_drive == 2'b01, "R2 lines low", line_drive, 1);
        check(if_en == 1'b0, "R2 disabled", if_en, 0);

        // R4 again from cycle with divider 1
        go_run(1);

        // R3 off, both codes
        for (int m = 0; m < 2; m++) begin
            @(negedge kclk); pwr_mode = m[1:0];
            repeat (8) @(negedge kclk);
            check(line_drive == 2'b10, "R3 lines high", line_drive, 2);
            check(if_en == 1'b0, "R3 disabled", if_en, 0);
            @(negedge kclk); pwr_mode = 2'b11;
            repeat (2) @(negedge kclk);
            check(if_en == 1'b0, "R4 no enable right after on", if_en, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule